// File: doc/BRIEF.md
# I2C Register Bank Slave

This block is a slave on a two-wire I2C-compatible bus that lets a bus master read and write a small bank of byte-wide registers. The bank holds eight registers by default. Both bus lines are oversampled by the fast system clock. Each line passes through a short synchronizer and an edge detector before any protocol decoding. SDA is driven open-drain: the block only ever pulls the line low, through `sda_oe_o`.

The device answers to one of two 7-bit addresses. The top bit of the address is 1. Bit 5 comes from a strap input. Bits 4 to 0 are 0. The first byte of every transfer is the address followed by a direction bit.

In a write, the next byte selects a starting register. The bytes after it fill that register and the ones above it. In a read, data flows from the current register pointer onward, and the pointer stops at the top register. The pointer keeps its value between transfers. A master can therefore set the pointer in a write, issue a repeated start, and read from that register.

A parallel host port gives direct access to the same registers. A bus write takes priority if both sides write in the same cycle.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {1, addr_strap_i, 00000} by holding SDA low during the ninth clock pulse. Any other address gets no acknowledge, and the slave ignores the bus until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one is recognized in any state. A start always begins a new address byte. A stop always returns the slave to idle with SDA released.
- R3: In a write, the byte after the address is a subaddress. A subaddress below 8 is acknowledged and loaded into the pointer. Each later byte is acknowledged and stored at the pointer, after which the pointer advances by one but never beyond 7.
- R4: A subaddress of 8 or more is not acknowledged. The slave returns to idle, and later bytes of that transfer get no acknowledge and change no register.
- R5: In a read, the slave sends the register at the pointer MSB first. After each byte the master acknowledges, the pointer advances by one, saturating at 7, so register 7 is repeated once the top is reached.
- R6: A master NACK ends a read: the slave releases SDA and stays silent on further SCL pulses until a start.
- R7: The pointer keeps its value across stops, repeated starts, rejected subaddresses and foreign addresses.
- R8: The slave changes its SDA drive only while the synchronized SCL is low. It releases SDA during the master's acknowledge slot of a read.
- R9: A start or stop inside a data byte aborts the byte without writing any register.
- R10: host_rdata_o shows the register selected by host_idx_i. With host_we_i high, host_wdata_i is stored into that register on the next clock edge.
- R11: Reset clears every register to 0 and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low |
| addr_strap_i | input | 1 | Selects bit 5 of the device address |
| host_idx_i | input | 3 | Host port register select |
| host_we_i | input | 1 | Host port write enable |
| host_wdata_i | input | 8 | Host port write data |
| host_rdata_o | output | 8 | Host port read data |

## Verification
The assertions check, on every cycle, several properties that must hold at all times. A start or stop always lands in the correct state. The data line is released whenever the slave is idle. The slave only starts pulling SDA while SCL is low. A rejected subaddress or a master NACK leads straight to idle. A matching address is followed by an acknowledge. A host write shows up on the host read port.

Some behaviours appear only in the bench scenarios, because they depend on whole byte sequences. These are: pointer saturation during auto-increment writes and reads, the pointer surviving across transfers, aborts in the middle of a byte, silence toward a foreign address, and the bytes actually serialized on the wire.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DACK,
    ST_SUB,
    ST_SACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } rb_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sq;
  logic              prev;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq   <= '1;
      prev <= 1'b1;
    end else begin
      sq   <= {sq[STAGES-2:0], line_i};
      prev <= sq[STAGES-1];
    end
  end

  assign level_o = sq[STAGES-1];
  assign rise_o  = sq[STAGES-1] & ~prev;
  assign fall_o  = ~sq[STAGES-1] & prev;
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
  parameter int NREGS = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_idx_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_idx_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o
);
  logic [DW-1:0] mem [NREGS];

  for (genvar gr = 0; gr < NREGS; gr++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[gr] <= '0;
      end else if (bus_we_i && bus_idx_i == AW'(gr)) begin
        mem[gr] <= bus_wdata_i;
      end else if (host_we_i && host_idx_i == AW'(gr)) begin
        mem[gr] <= host_wdata_i;
      end
    end
  end

  assign bus_rdata_o  = mem[bus_idx_i];
  assign host_rdata_o = mem[host_idx_i];

  // R10
  host_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !bus_we_i) |=>
      (host_idx_i != $past(host_idx_i)) || (host_rdata_o == $past(host_wdata_i)));
endmodule

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
  import i2c_rb_pkg::*;
#(
  parameter int           NREGS     = 8,
  parameter int           DW        = 8,
  parameter logic [6:0]   ADDR_BASE = 7'b100_0000,
  parameter int           STRAP_POS = 5,
  localparam int          AW        = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_i,
  input  logic          scl_lvl_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_lvl_i,
  input  logic          sda_rise_i,
  input  logic          sda_fall_i,
  input  logic [DW-1:0] rdata_i,
  output logic          we_o,
  output logic [AW-1:0] idx_o,
  output logic [DW-1:0] wdata_o,
  output logic          sda_oe_o
);
  localparam int            CW       = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);
  localparam logic [AW-1:0] TOP      = AW'(NREGS - 1);
  localparam logic [DW-1:0] NREGS_W  = DW'(NREGS);

  rb_state_e     st;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] tx;
  logic [AW-1:0] ptr;
  logic          rw;
  logic          ack_ok;

  logic          start_ev, stop_ev, rx_done;
  logic [AW-1:0] ptr_nxt;
  logic [6:0]    dev_addr;

  assign start_ev = sda_fall_i & scl_lvl_i;
  assign stop_ev  = sda_rise_i & scl_lvl_i;
  assign rx_done  = scl_fall_i && (bitcnt == CNT_FULL);
  assign ptr_nxt  = (ptr == TOP) ? ptr : ptr + AW'(1);
  assign dev_addr = ADDR_BASE | (7'(strap_i) << STRAP_POS);

  assign we_o    = (st == ST_WDAT) && rx_done && !start_ev && !stop_ev;
  assign wdata_o = sh;
  // read path looks one register ahead while waiting on the master ack
  assign idx_o   = (st == ST_RACK) ? ptr_nxt : ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      ack_ok   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_ev) begin
      st       <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (start_ev) begin
      st       <= ST_DEV;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_DEV, ST_SUB, ST_WDAT: begin
          if (scl_rise_i && bitcnt != CNT_FULL) begin
            sh     <= {sh[DW-2:0], sda_lvl_i};
            bitcnt <= bitcnt + CW'(1);
          end else if (rx_done) begin
            bitcnt <= '0;
            if (st == ST_DEV) begin
              if (sh[7:1] == dev_addr) begin
                rw       <= sh[0];
                sda_oe_o <= 1'b1;
                st       <= ST_DACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_SUB) begin
              if (sh < NREGS_W) begin
                ptr      <= sh[AW-1:0];
                sda_oe_o <= 1'b1;
                st       <= ST_SACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              ptr      <= ptr_nxt;
              sda_oe_o <= 1'b1;
              st       <= ST_WACK;
            end
          end
        end
        ST_DACK: begin
          if (scl_fall_i) begin
            if (rw) begin
              tx       <= rdata_i;
              sda_oe_o <= ~rdata_i[DW-1];
              bitcnt   <= '0;
              st       <= ST_RDAT;
            end else begin
              sda_oe_o <= 1'b0;
              st       <= ST_SUB;
            end
          end
        end
        ST_SACK, ST_WACK: begin
          if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            st       <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall_i) begin
            if (bitcnt == CNT_LAST) begin
              sda_oe_o <= 1'b0;
              st       <= ST_RACK;
            end else begin
              tx       <= {tx[DW-2:0], 1'b0};
              sda_oe_o <= ~tx[DW-2];
              bitcnt   <= bitcnt + CW'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            ack_ok <= ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (ack_ok) begin
              ptr      <= ptr_nxt;
              tx       <= rdata_i;
              sda_oe_o <= ~rdata_i[DW-1];
              bitcnt   <= '0;
              st       <= ST_RDAT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: begin
          st       <= ST_IDLE;
          sda_oe_o <= 1'b0;
        end
      endcase
    end
  end

  // R2
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ev |=> (st == ST_IDLE && !sda_oe_o));

  // R2
  start_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev |=> (st == ST_DEV && bitcnt == '0));

  // R1
  addr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DEV && rx_done && !start_ev && !stop_ev && sh[7:1] == dev_addr) |=> sda_oe_o);

  // R4
  bad_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SUB && rx_done && !start_ev && !stop_ev && sh >= NREGS_W) |=>
      (st == ST_IDLE && !sda_oe_o));

  // R6
  nack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RACK && scl_fall_i && !scl_rise_i && !ack_ok && !start_ev && !stop_ev) |=>
      (st == ST_IDLE));

  // R6
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);

  // R8
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_lvl_i));
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         NREGS       = 8,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_BASE   = 7'b100_0000,
  parameter int         STRAP_POS   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic                     addr_strap_i,
  input  logic [$clog2(NREGS)-1:0] host_idx_i,
  input  logic                     host_we_i,
  input  logic [DW-1:0]            host_wdata_i,
  output logic [DW-1:0]            host_rdata_o
);
  localparam int AW = $clog2(NREGS);

  logic [1:0] raw_w, lvl_w, rise_w, fall_w;
  assign raw_w = {sda_i, scl_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_w[gi]),
      .level_o(lvl_w[gi]),
      .rise_o (rise_w[gi]),
      .fall_o (fall_w[gi])
    );
  end

  logic          bus_we;
  logic [AW-1:0] bus_idx;
  logic [DW-1:0] bus_wdata, bus_rdata;

  i2c_rb_ctrl #(
    .NREGS    (NREGS),
    .DW       (DW),
    .ADDR_BASE(ADDR_BASE),
    .STRAP_POS(STRAP_POS)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (addr_strap_i),
    .scl_lvl_i (lvl_w[0]),
    .scl_rise_i(rise_w[0]),
    .scl_fall_i(fall_w[0]),
    .sda_lvl_i (lvl_w[1]),
    .sda_rise_i(rise_w[1]),
    .sda_fall_i(fall_w[1]),
    .rdata_i   (bus_rdata),
    .we_o      (bus_we),
    .idx_o     (bus_idx),
    .wdata_o   (bus_wdata),
    .sda_oe_o  (sda_oe_o)
  );

  i2c_rb_regs #(
    .NREGS(NREGS),
    .DW   (DW)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we),
    .bus_idx_i   (bus_idx),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .host_we_i   (host_we_i),
    .host_idx_i  (host_idx_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o)
  );
endmodule

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int WD_CYCLES  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic       strap = 1'b0;
  logic [2:0] host_idx = '0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;
  logic [7:0] mdl [8];
  int   mptr = 0;
  logic [7:0] wbuf [16];

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regbank_slave dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .addr_strap_i(strap),
    .host_idx_i  (host_idx),
    .host_we_i   (host_we),
    .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata)
  );

  function automatic logic [6:0] dev_addr(input logic s);
    return 7'h40 | (7'(s) << 5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1;   qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; qwait();
    scl = 1'b1; qwait();
    s = sda_line; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
    // R8: with the master leaving SDA high, the line must read high
    if (!mack) check("R8 released in ack slot", s, 1);
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++) begin
      host_idx = 3'(r);
      @(negedge clk);
      check(req, host_rdata, mdl[r]);
    end
  endtask

  task automatic host_write(input int r, input logic [7:0] v);
    host_idx = 3'(r); host_wdata = v; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    mdl[r] = v;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [7:0] sub, input int n,
                           input bit do_stop);
    logic ack;
    bit   hit;
    hit = (a == dev_addr(strap));
    bus_start();
    write_byte({a, 1'b0}, ack);
    check("R1 write address ack", ack, hit);
    if (!hit) begin bus_stop(); return; end
    write_byte(sub, ack);
    if (sub >= 8) begin
      check("R4 bad subaddress nack", ack, 0);
      write_byte(8'hA5, ack);
      check("R4 byte after bad subaddress ignored", ack, 0);
      bus_stop();
      return;
    end
    check("R3 subaddress ack", ack, 1);
    mptr = sub;
    for (int k = 0; k < n; k++) begin
      write_byte(wbuf[k], ack);
      check("R3 data ack", ack, 1);
      mdl[mptr] = wbuf[k];
      if (mptr < 7) mptr++;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic bus_read(input logic [6:0] a, input int n);
    logic       ack, s;
    logic [7:0] b;
    bit         hit;
    hit = (a == dev_addr(strap));
    bus_start();
    write_byte({a, 1'b1}, ack);
    check("R1 read address ack", ack, hit);
    if (!hit) begin
      clk_bit(1'b1, s);
      check("R1 foreign address silent", s, 1);
      bus_stop();
      return;
    end
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, b);
      check("R5 read data", b, mdl[mptr]);
      if (k != n - 1 && mptr < 7) mptr++;
    end
    clk_bit(1'b1, s);
    check("R6 silent after nack", s, 1);
    bus_stop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic s;
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 8; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 sda released", sda_oe, 0);
    check_regs("R11 reset registers");

    // R3 single register, R7 pointer kept into repeated-start read
    wbuf[0] = 8'h3C;
    bus_write(dev_addr(strap), 8'd3, 1, 1);
    check_regs("R3 single write");
    bus_write(dev_addr(strap), 8'd3, 0, 0);
    bus_read(dev_addr(strap), 1);

    // R3 auto-increment with saturation at register 7
    wbuf[0] = 8'h51; wbuf[1] = 8'h62; wbuf[2] = 8'h73; wbuf[3] = 8'h84; wbuf[4] = 8'h95;
    bus_write(dev_addr(strap), 8'd5, 5, 1);
    check_regs("R3 autoinc saturating write");

    // R5 read sticking at top register
    bus_write(dev_addr(strap), 8'd4, 0, 0);
    bus_read(dev_addr(strap), 7);

    // R1 foreign address while strap selects the other one
    strap = 1'b1;
    wbuf[0] = 8'hEE;
    bus_write(dev_addr(1'b0), 8'd1, 1, 1);
    bus_read(dev_addr(1'b0), 1);
    check_regs("R1 foreign address no write");
    bus_write(dev_addr(1'b1), 8'd0, 1, 1);
    check_regs("R1 strap address write");

    // R4 out-of-range subaddress, R7 pointer unchanged
    bus_write(dev_addr(strap), 8'd8, 0, 1);
    bus_write(dev_addr(strap), 8'd200, 0, 1);
    check_regs("R4 registers unchanged");
    bus_read(dev_addr(strap), 1);

    // R10 host port write seen by the bus
    host_write(2, 8'hC7);
    check_regs("R10 host write");
    bus_write(dev_addr(strap), 8'd2, 0, 0);
    bus_read(dev_addr(strap), 2);

    // R9 / R2 stop in the middle of a data byte
    wbuf[0] = 8'h00;
    bus_write(dev_addr(strap), 8'd6, 0, 0);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
    bus_stop();
    check("R2 idle after stop", sda_oe, 0);
    check_regs("R9 stop mid-byte no write");
    bus_read(dev_addr(strap), 1);

    // R9 / R2 repeated start in the middle of a data byte
    bus_write(dev_addr(strap), 8'd1, 0, 0);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    bus_read(dev_addr(strap), 2);
    check_regs("R9 start mid-byte no write");

    // constrained random transfers
    for (int it = 0; it < 40; it++) begin
      int         op;
      logic [6:0] a;
      if (it % 8 == 0) strap = 1'($urandom % 2);
      a  = ($urandom % 6 == 0) ? dev_addr(~strap) : dev_addr(strap);
      op = $urandom % 4;
      if (op == 0) begin
        host_write($urandom % 8, 8'($urandom));
      end else if (op == 1) begin
        bus_read(a, 1 + $urandom % 9);
      end else begin
        int n;
        n = 1 + $urandom % 5;
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        bus_write(a, 8'($urandom % 10), n, 1);
        check_regs("R3 random write");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule